// File: doc/BRIEF.md
# Flag-Setting ALU with Shifter

This block is the arithmetic, logic and shift datapath of a small 8-bit accumulator-style processor. It receives the full instruction word, the values read from the two operand registers (sX and sY), and the current carry and zero flags. It returns the operation result, the new zero and carry flags, and a write strobe for sX. The register file, memory access and program flow are outside the block. The caller sends the returned flags back on `carry_i` and `zero_i`, so carry-chained add and subtract work across several instructions.

The second operand comes from one of two places, chosen by a single select bit in the instruction: either the 8-bit constant inside the instruction or the sY register value. Two operations change only the flags and do not write: a flag-only AND and a flag-only subtraction. Shift and rotate variants are chosen by a 4-bit subcode. Instruction words the block does not handle produce no write and pass the incoming flags through unchanged.

All outputs are registered. An instruction presented before a rising clock edge shows its results after that edge. An asynchronous active-low reset clears every output. The block has no states beyond this output register.

Top module: `alu_flag_unit`

## Requirements
- R1: The instruction word is 18 bits. The opcode is in bits 17..13. Bit 12 selects the second operand: 0 selects the constant in bits 7..0, and 1 selects `sy_i`. Bits 11..8 (the sX address) do not affect the outputs.
- R2: Opcodes 00101, 00110 and 00111 write sX AND, OR and XOR the operand respectively. Each sets the write strobe and clears carry.
- R3: Opcode 01001 computes sX AND operand without writing. The write strobe is 0, the result shows the AND value, and carry is set when that value has an odd number of ones.
- R4: Opcode 01010 computes sX minus operand without writing. The write strobe is 0, and carry is set when the operand exceeds sX (a borrow).
- R5: Opcode 01100 writes sX plus operand, and opcode 01101 writes sX plus operand plus `carry_i`. Carry is the carry out of bit 7.
- R6: Opcode 01110 writes sX minus operand, and opcode 01111 writes sX minus operand minus `carry_i`. Carry is set on a borrow.
- R7: For every supported operation, zero is set exactly when the 8-bit result is 0.
- R8: Opcode 10000 with a left subcode shifts sX left by one, and carry takes the old bit 7. The subcode in bits 3..0 sets the bit shifted into bit 0: 0000 uses `carry_i`, 0010 uses the old bit 7 (rotate), 0100 repeats the old bit 0, 0110 inserts 0, and 0111 inserts 1.
- R9: Opcode 10000 with a right subcode shifts sX right by one, and carry takes the old bit 0. The subcode sets the bit shifted into bit 7: 1000 uses `carry_i`, 1010 repeats the old bit 7, 1100 uses the old bit 0 (rotate), 1110 inserts 0, and 1111 inserts 1.
- R10: Any other opcode, and opcode 10000 with any other subcode, gives write strobe 0 and result 0, and passes `carry_i` and `zero_i` through unchanged.
- R11: Outputs update on the rising clock edge that samples the inputs. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 18 | Instruction word |
| sx_i | input | 8 | Value of register sX |
| sy_i | input | 8 | Value of register sY |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| result_o | output | 8 | Operation result |
| zero_o | output | 1 | New zero flag |
| carry_o | output | 1 | New carry flag |
| wr_en_o | output | 1 | Write strobe for sX |

## Verification
The bench targets several corner cases.

- **Carry and borrow edges.** Operands 0xFF plus 1, 0 minus 1, and equal values under a flag-only subtraction are applied. A design that inverts the borrow sense, or loses the ninth bit, returns the wrong carry and zero flags.
- **Carry-in on chained operations.** The chained add and subtract run with `carry_i` at both 0 and 1. A design that ignores the incoming carry gives a result that is off by one.
- **Fill bits of each shift subcode.** Every subcode, including the unused encodings, is swept with operands whose edge bits differ. A swapped fill source shows up as a wrong bit 0 or bit 7.
- **Flag-only and unknown encodings.** These are checked for a stray write strobe or altered flags. A design that writes on them would corrupt sX.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_AND     = 5'b00101,
        OP_OR      = 5'b00110,
        OP_XOR     = 5'b00111,
        OP_TEST    = 5'b01001,
        OP_COMPARE = 5'b01010,
        OP_ADD     = 5'b01100,
        OP_ADDCY   = 5'b01101,
        OP_SUB     = 5'b01110,
        OP_SUBCY   = 5'b01111,
        OP_SHIFT   = 5'b10000
    } opcode_e;

    typedef enum logic [3:0] {
        SH_LCARRY = 4'b0000,
        SH_LROT   = 4'b0010,
        SH_LKEEP  = 4'b0100,
        SH_LZERO  = 4'b0110,
        SH_LONE   = 4'b0111,
        SH_RCARRY = 4'b1000,
        SH_RKEEP  = 4'b1010,
        SH_RROT   = 4'b1100,
        SH_RZERO  = 4'b1110,
        SH_RONE   = 4'b1111
    } shift_e;

    localparam int OPC_W = 5;
    localparam int SUB_W = 4;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    always_comb begin
        res_o = '0;
        c_o   = 1'b0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_TEST: begin
                res_o = a_i & b_i;
                c_o   = ^(a_i & b_i);
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] a_ext, b_ext, cin_ext, total;

    assign a_ext = {1'b0, a_i};
    assign b_ext = {1'b0, b_i};
    assign cin_ext = {{DATA_W{1'b0}}, cin_i};

    always_comb begin
        total = '0;
        case (op_i)
            OP_ADD:     total = a_ext + b_ext;
            OP_ADDCY:   total = a_ext + b_ext + cin_ext;
            OP_SUB,
            OP_COMPARE: total = a_ext - b_ext;
            OP_SUBCY:   total = a_ext - b_ext - cin_ext;
            default:    total = '0;
        endcase
        res_o = total[DATA_W-1:0];
        c_o   = total[DATA_W];
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              valid_o
);
    localparam int MSB = DATA_W - 1;

    logic fill;
    logic go_left;

    always_comb begin
        fill    = 1'b0;
        valid_o = 1'b1;
        go_left = 1'b1;
        case (shift_e'(sub_i))
            SH_LCARRY: fill = cin_i;
            SH_LROT:   fill = a_i[MSB];
            SH_LKEEP:  fill = a_i[0];
            SH_LZERO:  fill = 1'b0;
            SH_LONE:   fill = 1'b1;
            SH_RCARRY: begin fill = cin_i;    go_left = 1'b0; end
            SH_RKEEP:  begin fill = a_i[MSB]; go_left = 1'b0; end
            SH_RROT:   begin fill = a_i[0];   go_left = 1'b0; end
            SH_RZERO:  begin fill = 1'b0;     go_left = 1'b0; end
            SH_RONE:   begin fill = 1'b1;     go_left = 1'b0; end
            default:   valid_o = 1'b0;
        endcase
        if (go_left) begin
            res_o = {a_i[MSB-1:0], fill};
            c_o   = a_i[MSB];
        end else begin
            res_o = {fill, a_i[MSB:1]};
            c_o   = a_i[0];
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_AW = 4,
    localparam int INSTR_W = OPC_W + 1 + REG_AW + DATA_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  sx_i,
    input  logic [DATA_W-1:0]  sy_i,
    input  logic               carry_i,
    input  logic               zero_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               zero_o,
    output logic               carry_o,
    output logic               wr_en_o
);
    localparam int SEL_BIT = REG_AW + DATA_W;

    opcode_e           opc;
    logic [SUB_W-1:0]  sub;
    logic [DATA_W-1:0] operand;
    logic              unused_sx_addr;

    assign opc            = opcode_e'(instr_i[INSTR_W-1 -: OPC_W]);
    assign sub            = instr_i[SUB_W-1:0];
    assign operand        = instr_i[SEL_BIT] ? sy_i : instr_i[DATA_W-1:0];
    assign unused_sx_addr = ^instr_i[SEL_BIT-1 -: REG_AW];

    logic [DATA_W-1:0] log_r, ari_r, sh_r;
    logic              log_c, ari_c, sh_c, sh_ok;

    alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op_i(opc), .a_i(sx_i), .b_i(operand), .res_o(log_r), .c_o(log_c)
    );

    alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_i(opc), .a_i(sx_i), .b_i(operand), .cin_i(carry_i),
        .res_o(ari_r), .c_o(ari_c)
    );

    alu_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .sub_i(sub), .a_i(sx_i), .cin_i(carry_i),
        .res_o(sh_r), .c_o(sh_c), .valid_o(sh_ok)
    );

    logic [DATA_W-1:0] nxt_res;
    logic              nxt_c, nxt_z, nxt_we, nxt_known;

    always_comb begin
        nxt_res   = '0;
        nxt_c     = carry_i;
        nxt_known = 1'b1;
        nxt_we    = 1'b0;
        case (opc)
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = log_r; nxt_c = log_c; nxt_we = 1'b1;
            end
            OP_TEST: begin
                nxt_res = log_r; nxt_c = log_c;
            end
            OP_COMPARE: begin
                nxt_res = ari_r; nxt_c = ari_c;
            end
            OP_ADD, OP_ADDCY, OP_SUB, OP_SUBCY: begin
                nxt_res = ari_r; nxt_c = ari_c; nxt_we = 1'b1;
            end
            OP_SHIFT: begin
                if (sh_ok) begin
                    nxt_res = sh_r; nxt_c = sh_c; nxt_we = 1'b1;
                end else begin
                    nxt_known = 1'b0;
                end
            end
            default: nxt_known = 1'b0;
        endcase
        nxt_z = nxt_known ? (nxt_res == '0) : zero_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_o <= '0;
            zero_o   <= 1'b0;
            carry_o  <= 1'b0;
            wr_en_o  <= 1'b0;
        end else begin
            result_o <= nxt_res;
            zero_o   <= nxt_z;
            carry_o  <= nxt_c;
            wr_en_o  <= nxt_we;
        end
    end

    // R3 and R4: flag-only operations never raise the write strobe
    assert_flag_only_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[INSTR_W-1 -: OPC_W] inside {5'b01001, 5'b01010}) |=> !wr_en_o);

    assert_logic_clears_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[INSTR_W-1 -: OPC_W] inside {5'b00101, 5'b00110, 5'b00111}) |=> (wr_en_o && !carry_o));

    assert_zero_tracks_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (zero_o == (result_o == '0)));

    assert_left_shift_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[INSTR_W-1 -: OPC_W] == 5'b10000 && instr_i[3:0] inside {4'h0, 4'h2, 4'h4, 4'h6, 4'h7})
        |=> (carry_o == $past(sx_i[DATA_W-1])));

    assert_right_shift_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[INSTR_W-1 -: OPC_W] == 5'b10000 && instr_i[3:0] inside {4'h8, 4'hA, 4'hC, 4'hE, 4'hF})
        |=> (carry_o == $past(sx_i[0])));

    assert_unknown_passes_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(instr_i[INSTR_W-1 -: OPC_W] inside {5'b00101, 5'b00110, 5'b00111, 5'b01001, 5'b01010,
                                                5'b01100, 5'b01101, 5'b01110, 5'b01111, 5'b10000}))
        |=> (!wr_en_o && carry_o == $past(carry_i) && zero_o == $past(zero_i)));

endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] instr = '0;
    logic [7:0]  sx = '0, sy = '0;
    logic        cin = 1'b0, zin = 1'b0;
    logic [7:0]  result;
    logic        zero, carry, wr_en;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu_flag_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .sx_i(sx), .sy_i(sy),
        .carry_i(cin), .zero_i(zin), .result_o(result), .zero_o(zero),
        .carry_o(carry), .wr_en_o(wr_en)
    );

    function automatic string tag_of(int op, int sb);
        case (op)
            5, 6, 7:    return "R2";
            9:          return "R3";
            10:         return "R4";
            12, 13:     return "R5";
            14, 15:     return "R6";
            16:         return (sb inside {0, 2, 4, 6, 7}) ? "R8" :
                               (sb inside {8, 10, 12, 14, 15}) ? "R9" : "R10";
            default:    return "R10";
        endcase
    endfunction

    task automatic model(input logic [17:0] ins, input int x, input int y_reg,
                         input int ci, input int zi,
                         output int r, output int c, output int z, output int we);
        int op, b, t, sb, fill;
        bit ok;
        op = ins / 8192;
        b  = ((ins / 4096) % 2 == 1) ? y_reg : (ins % 256);
        sb = ins % 16;
        ok = 1; r = 0; c = ci; we = 1;
        case (op)
            5:  begin r = x & b; c = 0; end
            6:  begin r = x | b; c = 0; end
            7:  begin r = x ^ b; c = 0; end
            9:  begin r = x & b; c = $countones(r) % 2; we = 0; end
            10: begin t = x - b; c = (t < 0); r = (t + 256) % 256; we = 0; end
            12: begin t = x + b; c = (t > 255); r = t % 256; end
            13: begin t = x + b + ci; c = (t > 255); r = t % 256; end
            14: begin t = x - b; c = (t < 0); r = (t + 512) % 256; end
            15: begin t = x - b - ci; c = (t < 0); r = (t + 512) % 256; end
            16: begin
                if (sb inside {0, 2, 4, 6, 7}) begin
                    fill = (sb == 0) ? ci : (sb == 2) ? x / 128 : (sb == 4) ? x % 2 : (sb == 6) ? 0 : 1;
                    r = (x * 2) % 256 + fill; c = x / 128;
                end else if (sb inside {8, 10, 12, 14, 15}) begin
                    fill = (sb == 8) ? ci : (sb == 10) ? x / 128 : (sb == 12) ? x % 2 : (sb == 14) ? 0 : 1;
                    r = x / 2 + fill * 128; c = x % 2;
                end else ok = 0;
            end
            default: ok = 0;
        endcase
        if (ok) z = (r == 0);
        else begin r = 0; c = ci; z = zi; we = 0; end
    endtask

    task automatic check(input string req, input int r, input int c, input int z, input int we);
        n_chk++;
        if (result !== r[7:0] || carry !== c[0] || zero !== z[0] || wr_en !== we[0]) begin
            n_bad++;
            $display("FAIL %s instr=%h sx=%h sy=%h cin=%0d: got r=%h c=%b z=%b we=%b, expected r=%h c=%0d z=%0d we=%0d",
                     req, instr, sx, sy, cin, result, carry, zero, wr_en, r[7:0], c, z, we);
        end
    endtask

    task automatic apply(input logic [17:0] ins, input logic [7:0] x, input logic [7:0] y,
                         input logic ci, input logic zi, input string req);
        int r, c, z, we;
        @(negedge clk);
        instr = ins; sx = x; sy = y; cin = ci; zin = zi;
        model(ins, int'(x), int'(y), int'(ci), int'(zi), r, c, z, we);
        @(negedge clk);
        check(req == "" ? tag_of(int'(ins[17:13]), int'(ins[3:0])) : req, r, c, z, we);
    endtask

    function automatic logic [17:0] mk(int op, bit reg_sel, int xaddr, int low);
        return {op[4:0], reg_sel, xaddr[3:0], low[7:0]};
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1;
                n_chk++; n_bad++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        // R11: reset clears outputs
        instr = mk(12, 0, 0, 8'hFF); sx = 8'hFF; cin = 1;
        repeat (3) @(negedge clk);
        check("R11", 0, 0, 0, 0);
        rst_n = 1'b1;

        // R1: operand source select and sX address independence
        apply(mk(12, 0, 3, 8'h05), 8'h10, 8'h70, 0, 0, "R1");
        apply(mk(12, 1, 3, 8'h05), 8'h10, 8'h70, 0, 0, "R1");
        apply(mk(12, 1, 15, 8'hA5), 8'h10, 8'h70, 0, 0, "R1");
        // R5 carry edge, R7 zero
        apply(mk(12, 0, 0, 8'h01), 8'hFF, 8'h00, 0, 0, "R5");
        apply(mk(13, 0, 0, 8'hFF), 8'h00, 8'h00, 1, 0, "R5");
        // R6 borrow edges
        apply(mk(14, 0, 0, 8'h01), 8'h00, 8'h00, 0, 0, "R6");
        apply(mk(15, 0, 0, 8'h00), 8'h00, 8'h00, 1, 0, "R6");
        apply(mk(15, 0, 0, 8'h00), 8'h01, 8'h00, 1, 1, "R7");
        // R4 equal operands
        apply(mk(10, 1, 0, 0), 8'h5A, 8'h5A, 1, 0, "R4");
        // R3 parity
        apply(mk(9, 0, 0, 8'h07), 8'hFF, 8'h00, 0, 0, "R3");
        // R8/R9 fill sources with differing edge bits
        for (int s = 0; s < 16; s++) begin
            apply(mk(16, 0, 0, s), 8'h80, 8'h00, 1, 0, "");
            apply(mk(16, 0, 0, s), 8'h01, 8'h00, 0, 1, "");
        end
        // R10 unknown opcodes
        for (int op = 0; op < 32; op++)
            for (int k = 0; k < 4; k++)
                apply(mk(op, $urandom % 2, $urandom, $urandom), 8'($urandom), 8'($urandom),
                      1'($urandom), 1'($urandom), "");
        // random sweep of every operation, subcode and carry value
        for (int i = 0; i < 10; i++) begin
            int ops[10] = '{5, 6, 7, 9, 10, 12, 13, 14, 15, 16};
            for (int k = 0; k < 200; k++)
                apply(mk(ops[i], $urandom % 2, $urandom, $urandom), 8'($urandom), 8'($urandom),
                      1'(k % 2), 1'($urandom), "");
        end
        // R11: reset mid-run
        @(negedge clk);
        instr = mk(12, 0, 0, 8'h01); sx = 8'hFF;
        rst_n = 1'b0;
        #1;
        check("R11", 0, 0, 0, 0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule